// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Arbiter

This block decides which of ten interrupt vectors the core should take next. Each vector has a request input and a one-bit level select. A request pulse is latched as pending. Pending vectors compete according to their effective level, which is one of three levels: top above high above low. A vector wins only when its level is strictly above the level now being serviced. The winner is announced with a one-cycle acknowledge and its vector address. Acknowledging a vector also enters its level into the in-service record.

The core reports each return from an interrupt on a one-cycle strobe. The block then removes the highest active level from its in-service record. Nesting is therefore allowed: an interrupt may be cut into by one of a higher level, and the levels unwind in reverse order. The core's global interrupt-enable gates every grant. While it is low, requests stay pending and wait.

Top module: `intarb_top`

## Requirements
- R1: When acknowledged, vector index i (0 to 9) is reported on `vecAddr` as 3 + 8*i, which gives 0x03, 0x0B, ... up to 0x4B.
- R2: For vectors 0 and 1, a `levelSel` bit of 1 gives the top level and 0 gives low. For vectors 2 to 9, 1 gives high and 0 gives low. `svcLevel` encodes the levels as 0 = none, 1 = low, 2 = high, 3 = top.
- R3: A one-cycle pulse on `reqIn[i]` sets a pending bit that stays set until that vector is acknowledged. An acknowledge clears only the bit of the winning vector.
- R4: `ackOut` pulses for one cycle, with `vecAddr` valid, on the clock after a qualifying pending bit is visible. This happens only if `intEnable` was high on that clock. While the enable is low, no grant is made and the requests stay pending.
- R5: When pending vectors of different levels qualify at once, the highest level wins.
- R6: Among qualifying vectors of the same level, the lowest index (lowest address) wins.
- R7: A pending vector whose level is equal to or below `svcLevel` is not acknowledged, and it stays pending.
- R8: An acknowledge adds the granted level to the in-service record. `svcLevel` always shows the highest level in that record.
- R9: A pulse on `retiIn` removes the highest active level from the in-service record. `svcLevel` then falls to the next active level, or to 0 when none is left.
- R10: During and after reset, there is no pending request, `ackOut` is 0 and `svcLevel` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqIn | input | NUM_VEC | Request pulses, one per vector |
| levelSel | input | NUM_VEC | Level choice per vector (see R2) |
| intEnable | input | 1 | Global interrupt enable from the core |
| retiIn | input | 1 | Return-from-interrupt strobe |
| ackOut | output | 1 | One-cycle grant strobe |
| vecAddr | output | ADDR_W | Address of the last granted vector |
| svcLevel | output | 2 | Highest level now in service |

## Verification
The bench builds the block with its default parameters: ten vectors, two of which can take the top level, base 0x03, step 8 and an 8-bit address. With these values the full address map from 0x03 to 0x4B can be reached. All three levels can be nested at once, and the rule that only vectors 0 and 1 can reach the top level can be tested against a vector that cannot. Directed runs cover ties at one level, mixed-level contention, refusal while a level is in service, ordered unwinding on return, and grants held back by the enable. Throughout each run, a behavioural queue model is compared on every clock.

// File: rtl/intarb_pkg.sv
package intarb_pkg;

  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_HIGH = 2'd2,
    LVL_TOP  = 2'd3
  } level_e;

  typedef struct packed {
    logic   grant;
    logic   pop;
    level_e grantLvl;
  } ctrlStrobe_t;

endpackage

// File: rtl/intarb_ctrl.sv
module intarb_ctrl
  import intarb_pkg::*;
#(
  parameter int NUM_VEC       = 10,
  parameter int NUM_X_CAPABLE = 2,
  parameter int IDX_W         = 4
) (
  input  logic [NUM_VEC-1:0] pendQ,
  input  logic [NUM_VEC-1:0] levelSel,
  input  level_e             curLvl,
  input  logic               intEnable,
  input  logic               retiIn,
  output ctrlStrobe_t        strb,
  output logic [IDX_W-1:0]   winIdx,
  output logic [NUM_VEC-1:0] winMask
);

  level_e vecLvl [NUM_VEC];

  // Effective level per vector: only the first NUM_X_CAPABLE may reach the top level
  for (genvar g = 0; g < NUM_VEC; g++) begin : g_lvl
    if (g < NUM_X_CAPABLE) begin : g_top
      assign vecLvl[g] = levelSel[g] ? LVL_TOP : LVL_LOW;
    end else begin : g_high
      assign vecLvl[g] = levelSel[g] ? LVL_HIGH : LVL_LOW;
    end
  end

  level_e           bestLvl;
  logic [IDX_W-1:0] bestIdx;
  logic             found;

  // Scan from the top index down so that a lower index overrides on equal level
  always_comb begin
    bestLvl = LVL_NONE;
    bestIdx = '0;
    found   = 1'b0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (pendQ[i] && (vecLvl[i] > curLvl) && (vecLvl[i] >= bestLvl)) begin
        bestLvl = vecLvl[i];
        bestIdx = IDX_W'(i);
        found   = 1'b1;
      end
    end
  end

  always_comb begin
    strb.grant    = found & intEnable;
    strb.pop      = retiIn;
    strb.grantLvl = bestLvl;
    winIdx        = bestIdx;
    winMask       = strb.grant ? (NUM_VEC'(1) << bestIdx) : '0;
  end

endmodule

// File: rtl/intarb_dpath.sv
module intarb_dpath
  import intarb_pkg::*;
#(
  parameter int NUM_VEC  = 10,
  parameter int ADDR_W   = 8,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8,
  parameter int IDX_W    = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_VEC-1:0] reqIn,
  input  ctrlStrobe_t        strb,
  input  logic [IDX_W-1:0]   winIdx,
  input  logic [NUM_VEC-1:0] winMask,
  output logic [NUM_VEC-1:0] pendQ,
  output level_e             curLvl,
  output logic [ADDR_W-1:0]  vecAddr,
  output logic               ackOut
);

  // In-service record: bit0 low, bit1 high, bit2 top
  logic [2:0] inSvcQ;
  logic [2:0] popMask;
  logic [2:0] pushMask;

  always_comb begin
    if (inSvcQ[2])      curLvl = LVL_TOP;
    else if (inSvcQ[1]) curLvl = LVL_HIGH;
    else if (inSvcQ[0]) curLvl = LVL_LOW;
    else                curLvl = LVL_NONE;
  end

  always_comb begin
    popMask[2] = inSvcQ[2];
    popMask[1] = inSvcQ[1] & ~inSvcQ[2];
    popMask[0] = inSvcQ[0] & ~inSvcQ[1] & ~inSvcQ[2];
    if (!strb.pop) popMask = '0;
  end

  always_comb begin
    pushMask = '0;
    if (strb.grant) begin
      case (strb.grantLvl)
        LVL_LOW:  pushMask = 3'b001;
        LVL_HIGH: pushMask = 3'b010;
        LVL_TOP:  pushMask = 3'b100;
        default:  pushMask = 3'b000;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ   <= '0;
      inSvcQ  <= '0;
      ackOut  <= 1'b0;
      vecAddr <= '0;
    end else begin
      pendQ  <= (pendQ & ~winMask) | reqIn;
      inSvcQ <= (inSvcQ & ~popMask) | pushMask;
      ackOut <= strb.grant;
      if (strb.grant) begin
        vecAddr <= ADDR_W'(VEC_BASE) + ADDR_W'(winIdx) * ADDR_W'(VEC_STEP);
      end
    end
  end

endmodule

// File: rtl/intarb_top.sv
module intarb_top
  import intarb_pkg::*;
#(
  parameter int NUM_VEC       = 10,
  parameter int NUM_X_CAPABLE = 2,
  parameter int ADDR_W        = 8,
  parameter int VEC_BASE      = 3,
  parameter int VEC_STEP      = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_VEC-1:0] reqIn,
  input  logic [NUM_VEC-1:0] levelSel,
  input  logic               intEnable,
  input  logic               retiIn,
  output logic               ackOut,
  output logic [ADDR_W-1:0]  vecAddr,
  output logic [1:0]         svcLevel
);

  localparam int IDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

  ctrlStrobe_t        strb;
  logic [IDX_W-1:0]   winIdx;
  logic [NUM_VEC-1:0] winMask;
  logic [NUM_VEC-1:0] pendQ;
  level_e             curLvl;

  intarb_ctrl #(
    .NUM_VEC      (NUM_VEC),
    .NUM_X_CAPABLE(NUM_X_CAPABLE),
    .IDX_W        (IDX_W)
  ) u_ctrl (
    .pendQ    (pendQ),
    .levelSel (levelSel),
    .curLvl   (curLvl),
    .intEnable(intEnable),
    .retiIn   (retiIn),
    .strb     (strb),
    .winIdx   (winIdx),
    .winMask  (winMask)
  );

  intarb_dpath #(
    .NUM_VEC (NUM_VEC),
    .ADDR_W  (ADDR_W),
    .VEC_BASE(VEC_BASE),
    .VEC_STEP(VEC_STEP),
    .IDX_W   (IDX_W)
  ) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .reqIn  (reqIn),
    .strb   (strb),
    .winIdx (winIdx),
    .winMask(winMask),
    .pendQ  (pendQ),
    .curLvl (curLvl),
    .vecAddr(vecAddr),
    .ackOut (ackOut)
  );

  assign svcLevel = curLvl;

endmodule

// File: rtl/intarb_chk.sv
module intarb_chk #(
  parameter int NUM_VEC       = 10,
  parameter int NUM_X_CAPABLE = 2,
  parameter int ADDR_W        = 8,
  parameter int VEC_BASE      = 3,
  parameter int VEC_STEP      = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              intEnable,
  input logic              retiIn,
  input logic              ackOut,
  input logic [ADDR_W-1:0] vecAddr,
  input logic [1:0]        svcLevel
);

  logic [ADDR_W-1:0] offs;
  logic              aligned;
  int                vecIdx;

  assign offs    = vecAddr - ADDR_W'(VEC_BASE);
  assign aligned = (offs % ADDR_W'(VEC_STEP)) == '0;
  assign vecIdx  = int'(offs / ADDR_W'(VEC_STEP));

  AST_ADDR_FORM: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |-> (aligned && vecIdx < NUM_VEC)); // R1

  AST_TOP_ONLY_LOW_VECTORS: assert property (@(posedge clk) disable iff (!rstN)
    (ackOut && vecIdx >= NUM_X_CAPABLE) |-> (svcLevel != 2'd3)); // R2

  AST_ACK_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |-> $past(intEnable)); // R4

  AST_ACK_RAISES_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |-> (svcLevel > $past(svcLevel))); // R7

  AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !retiIn |=> (svcLevel >= $past(svcLevel))); // R8

  AST_RETURN_LOWERS: assert property (@(posedge clk) disable iff (!rstN)
    (retiIn && svcLevel != 2'd0) |=> (ackOut || svcLevel < $past(svcLevel))); // R9

endmodule

bind intarb_top intarb_chk #(
  .NUM_VEC      (NUM_VEC),
  .NUM_X_CAPABLE(NUM_X_CAPABLE),
  .ADDR_W       (ADDR_W),
  .VEC_BASE     (VEC_BASE),
  .VEC_STEP     (VEC_STEP)
) u_chk (.*);

// File: tb/tb_intarb_top.sv
module tb_intarb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  localparam int NX = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NV-1:0] reqIn = '0;
  logic [NV-1:0] levelSel = '0;
  logic          intEnable = 1'b1;
  logic          retiIn = 1'b0;
  logic          ackOut;
  logic [7:0]    vecAddr;
  logic [1:0]    svcLevel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intarb_top dut (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .levelSel(levelSel),
    .intEnable(intEnable), .retiIn(retiIn), .ackOut(ackOut),
    .vecAddr(vecAddr), .svcLevel(svcLevel)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit mPend [NV];
  int mStack [$];
  bit mAck;
  int mVec;

  function automatic int effLvl(int i, bit s);
    if (!s) return 1;
    return (i < NX) ? 3 : 2;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mPend[i]) mPend[i] = 0;
      mStack.delete();
      mAck = 0;
      mVec = 0;
    end else begin
      int top, best, bl;
      bit g;
      top = (mStack.size() > 0) ? mStack[$] : 0;
      best = -1;
      bl = 0;
      for (int i = 0; i < NV; i++) begin
        if (mPend[i] && effLvl(i, levelSel[i]) > top && effLvl(i, levelSel[i]) > bl) begin
          best = i;
          bl = effLvl(i, levelSel[i]);
        end
      end
      g = (best >= 0) && intEnable;
      if (retiIn && mStack.size() > 0) void'(mStack.pop_back());
      if (g) begin
        mStack.push_back(bl);
        mVec = 3 + 8 * best;
      end
      mAck = g;
      for (int i = 0; i < NV; i++)
        mPend[i] = (mPend[i] && !(g && i == best)) || reqIn[i];
    end
  end

  int seenAddr [$];
  int seenLvl [$];

  always @(negedge clk) begin
    if (rstN) begin
      chk("R4 ack vs model", int'(ackOut), int'(mAck));
      if (ackOut) chk("R1 addr vs model", int'(vecAddr), mVec);
      chk("R8 level vs model", int'(svcLevel), (mStack.size() > 0) ? mStack[$] : 0);
      if (ackOut) begin
        seenAddr.push_back(int'(vecAddr));
        seenLvl.push_back(int'(svcLevel));
      end
    end
  end

  task automatic pulseReq(logic [NV-1:0] m);
    @(negedge clk); reqIn = m;
    @(negedge clk); reqIn = '0;
  endtask

  task automatic doReti();
    @(negedge clk); retiIn = 1'b1;
    @(negedge clk); retiIn = 1'b0;
  endtask

  task automatic expectAck(string tag, int addr, int lvl);
    int k = 0;
    while (seenAddr.size() == 0 && k < 8) begin
      @(negedge clk); #1; k++;
    end
    if (seenAddr.size() == 0) chk({tag, " no ack"}, -1, addr);
    else begin
      chk({tag, " addr"}, seenAddr.pop_front(), addr);
      chk({tag, " level"}, seenLvl.pop_front(), lvl);
    end
  endtask

  task automatic expectNone(string tag, int n);
    repeat (n) @(negedge clk);
    #1;
    chk(tag, seenAddr.size(), 0);
  endtask

  task automatic checkSvc(string tag, int exp);
    #1;
    chk(tag, int'(svcLevel), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R10 ack in reset", int'(ackOut), 0);
    chk("R10 level in reset", int'(svcLevel), 0);
    @(negedge clk); rstN = 1'b1;
    expectNone("R10 no spurious ack", 3);

    // R1: every vector alone at low level
    for (int i = 0; i < NV; i++) begin
      pulseReq(NV'(1) << i);
      expectAck("R1 single vector", 3 + 8 * i, 1);
      doReti();
    end

    // R6 ties at low level, R7 refusal, R9 unwinding, R3 pending kept
    pulseReq(NV'(1) << 3 | NV'(1) << 7 | NV'(1) << 9);
    expectAck("R6 lowest index first", 8'h1B, 1);
    expectNone("R7 equal level refused", 4);
    checkSvc("R8 level low", 1);
    doReti();
    expectAck("R3 kept pending", 8'h3B, 1);
    doReti();
    expectAck("R6 last of tie", 8'h4B, 1);
    doReti();
    checkSvc("R9 empty after unwind", 0);

    // R5 mixed levels
    levelSel = '0;
    levelSel[0] = 1'b1;
    levelSel[6] = 1'b1;
    pulseReq(NV'(1) << 1 | NV'(1) << 6 | NV'(1) << 0);
    expectAck("R5 top wins", 8'h03, 3);
    expectNone("R7 lower refused under top", 4);
    doReti();
    expectAck("R5 high next", 8'h33, 2);
    doReti();
    expectAck("R5 low last", 8'h0B, 1);
    doReti();

    // R8 nesting upward, R9 pops in order
    pulseReq(NV'(1) << 5);
    expectAck("R8 nest low", 8'h2B, 1);
    pulseReq(NV'(1) << 6);
    expectAck("R8 nest high", 8'h33, 2);
    pulseReq(NV'(1) << 0);
    expectAck("R8 nest top", 8'h03, 3);
    doReti(); checkSvc("R9 pop to high", 2);
    doReti(); checkSvc("R9 pop to low", 1);
    doReti(); checkSvc("R9 pop to none", 0);

    // R2: vector 4 with select set is high, not top
    levelSel[4] = 1'b1;
    pulseReq(NV'(1) << 0);
    expectAck("R2 vector 0 top", 8'h03, 3);
    pulseReq(NV'(1) << 4);
    expectNone("R2 vector 4 not top", 4);
    doReti();
    expectAck("R2 vector 4 high", 8'h23, 2);
    doReti();

    // R4 enable gating
    intEnable = 1'b0;
    pulseReq(NV'(1) << 2);
    expectNone("R4 blocked while disabled", 5);
    @(negedge clk); intEnable = 1'b1;
    expectAck("R4 granted after enable", 8'h13, 1);
    doReti();
    expectNone("R3 no repeat after ack", 4);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R4 watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule